// File: doc/BRIEF.md
# Indirect Management Register Access Master

This block lets on-chip logic read and write the internal registers of an external management target that holds several register sets, each one selected by a device address. The target sits on a management bus (MDIO/SMI) at a bus address given on `cfg_bus_addr`. The block does not drive the bus pins itself. It talks to a frame-level port: it issues one read or write frame and waits for that frame's response.

When the bus address is zero, the target answers on every bus address. The block then sends the access straight to the target, with the device address used as the bus address. When the bus address is nonzero, the block reaches the device through two registers at the target's bus address: a command register at offset 0 and a data register at offset 1. Each command is preceded and followed by polling of the busy bit in the command register. The polling has a bounded number of tries, and the tries are spaced out.

The user side takes one request at a time. A request carries a device address, a register address, write data and a write flag. The block ends every request with exactly one of three one-cycle pulses: done, timeout or error. Read data is returned on a held output.

Top module: `smi_indirect_master`

## Requirements
- R1: After reset, `req_ready` is 1, `mio_req` is 0, and `rsp_done`, `rsp_timeout` and `rsp_error` are 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle until the cycle in which the completion pulse is shown.
- R3: With `cfg_bus_addr` equal to 0, a request produces exactly one frame, with no polling. That frame has `mio_phy` = device address, `mio_reg` = register address, and the write flag and write data passed through.
- R4: With a nonzero bus address, a read issues these frames to that bus address, in this order: a poll (read of offset 0), a write of the command word to offset 0, a poll, and a read of offset 1. The data of that last read appears on `rsp_rdata`.
- R5: With a nonzero bus address, a write issues these frames, in this order: a poll, a write of the write data to offset 1, a write of the command word to offset 0, and a poll.
- R6: The command word has bit 15 = 1 (start/busy) and bit 12 = 1 (clause-22 format). Bits 11:10 carry the opcode, 2 for a read and 1 for a write. Bits 9:5 carry the device address and bits 4:0 the register address. All other bits are 0.
- R7: A poll response with bit 15 set means busy. The next poll frame then starts `POLL_GAP`+2 cycles after the busy poll's frame. A response with bit 15 clear moves the sequence on to its next frame, which starts 2 cycles after the poll's frame.
- R8: A single poll phase that receives `POLL_LIMIT` busy responses ends the request with `rsp_timeout`, and no further frame is sent. If the busy bit clears on try number `POLL_LIMIT`, the request carries on. The try count starts again for each poll phase.
- R9: A frame response with `mio_rsp_err` = 1 ends the request at once with `rsp_error`, and no further frame is sent.
- R10: Each request ends with exactly one of `rsp_done`, `rsp_timeout` or `rsp_error`, each a one-cycle pulse. `rsp_rdata` changes only when a read completes and keeps its value across writes.
- R11: `mio_req` is a one-cycle strobe. No new frame starts until the response to the previous frame has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bus_addr | input | 5 | Bus address of the target; 0 selects direct access. Sampled when a request is taken |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Device address inside the target |
| req_reg | input | 5 | Register address inside the device |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle pulse: request completed |
| rsp_timeout | output | 1 | One-cycle pulse: busy polling gave up |
| rsp_error | output | 1 | One-cycle pulse: a frame returned an error |
| rsp_rdata | output | 16 | Data of the last completed read |
| mio_req | output | 1 | One-cycle frame strobe |
| mio_write | output | 1 | Frame is a write |
| mio_phy | output | 5 | Frame bus address |
| mio_reg | output | 5 | Frame register offset |
| mio_wdata | output | 16 | Frame write data |
| mio_rsp_valid | input | 1 | Frame response strobe |
| mio_rsp_err | input | 1 | Frame response carries an error |
| mio_rsp_rdata | input | 16 | Frame read data |

## Verification
A wrong sequence step or mode flag shows up on the very next `mio_req` as the wrong offset, bus address or command word. A bench that logs every frame with its cycle stamp therefore sees it within one frame. A poll counter that is off by one, or that is not cleared between phases, shows up only at the end of a long busy run. The bench tests this at the exact limit, one below it, and with two busy phases whose combined length exceeds the limit. A broken gap timer shows up as a wrong spacing between consecutive poll frames. A bad completion path shows up as a missing or doubled pulse, or as a stale or overwritten `rsp_rdata`.

// File: rtl/smi_im_pkg.sv
package smi_im_pkg;
    // frame field widths fixed by the management bus format
    localparam int AW = 5;
    localparam int DW = 16;

    // tunnel register offsets and command word layout
    localparam logic [AW-1:0] OFS_CMD  = 5'd0;
    localparam logic [AW-1:0] OFS_DATA = 5'd1;
    localparam int BUSY_BIT  = 15;
    localparam int CL22_BIT  = 12;
    localparam int OPC_LSB   = 10;
    localparam int DEV_LSB   = 5;
    localparam logic [1:0] OPC_RD = 2'd2;
    localparam logic [1:0] OPC_WR = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_GAP
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_DIRECT,
        OP_POLL,
        OP_WDATA,
        OP_WCMD,
        OP_RDATA
    } step_op_e;
endpackage

// File: rtl/smi_im_step_decode.sv
module smi_im_step_decode
    import smi_im_pkg::*;
(
    input  logic       tunnel,
    input  logic       wr,
    input  logic [1:0] step,
    output step_op_e   op,
    output logic       last
);
    always_comb begin
        op   = OP_DIRECT;
        last = 1'b1;
        if (tunnel) begin
            last = (step == 2'd3);
            unique case (step)
                2'd0: op = OP_POLL;
                2'd1: op = wr ? OP_WDATA : OP_WCMD;
                2'd2: op = wr ? OP_WCMD  : OP_POLL;
                default: op = wr ? OP_POLL : OP_RDATA;
            endcase
        end
    end
endmodule

// File: rtl/smi_im_cmd_word.sv
module smi_im_cmd_word
    import smi_im_pkg::*;
(
    input  logic          wr,
    input  logic [AW-1:0] dev,
    input  logic [AW-1:0] rg,
    output logic [DW-1:0] word
);
    always_comb begin
        word                        = '0;
        word[BUSY_BIT]              = 1'b1;
        word[CL22_BIT]              = 1'b1;
        word[OPC_LSB+1:OPC_LSB]     = wr ? OPC_WR : OPC_RD;
        word[DEV_LSB+AW-1:DEV_LSB]  = dev;
        word[AW-1:0]                = rg;
    end
endmodule

// File: rtl/smi_im_gap_timer.sv
module smi_im_gap_timer #(
    parameter int unsigned GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [CW-1:0] TOP = CW'(GAP - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = '0;
        else if (cnt_q != TOP)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= TOP;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == TOP);
endmodule

// File: rtl/smi_indirect_master.sv
module smi_indirect_master
    import smi_im_pkg::*;
#(
    parameter int unsigned POLL_LIMIT = 100,
    parameter int unsigned POLL_GAP   = 250000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_bus_addr,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_dev,
    input  logic [AW-1:0] req_reg,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_done,
    output logic          rsp_timeout,
    output logic          rsp_error,
    output logic [DW-1:0] rsp_rdata,
    output logic          mio_req,
    output logic          mio_write,
    output logic [AW-1:0] mio_phy,
    output logic [AW-1:0] mio_reg,
    output logic [DW-1:0] mio_wdata,
    input  logic          mio_rsp_valid,
    input  logic          mio_rsp_err,
    input  logic [DW-1:0] mio_rsp_rdata
);
    localparam int PCNT_W = $clog2(POLL_LIMIT + 1);
    localparam logic [PCNT_W-1:0] POLL_LAST = PCNT_W'(POLL_LIMIT - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [1:0]    step;
        logic          tunnel;
        logic          wr;
        logic [AW-1:0] bus;
        logic [AW-1:0] dev;
        logic [AW-1:0] rg;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic [PCNT_W-1:0] polls;
        logic          done;
        logic          tout;
        logic          err;
    } ctx_t;

    ctx_t     c_d, c_q;
    step_op_e op;
    logic     last;
    logic [DW-1:0] cmd;
    logic     tmr_start, tmr_expired;

    smi_im_step_decode u_step (
        .tunnel (c_q.tunnel),
        .wr     (c_q.wr),
        .step   (c_q.step),
        .op     (op),
        .last   (last)
    );

    smi_im_cmd_word u_cmd (
        .wr   (c_q.wr),
        .dev  (c_q.dev),
        .rg   (c_q.rg),
        .word (cmd)
    );

    smi_im_gap_timer #(.GAP(POLL_GAP)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .expired (tmr_expired)
    );

    // frame fields for the current step
    always_comb begin
        mio_write = 1'b0;
        mio_phy   = c_q.bus;
        mio_reg   = OFS_CMD;
        mio_wdata = '0;
        unique case (op)
            OP_DIRECT: begin
                mio_write = c_q.wr;
                mio_phy   = c_q.dev;
                mio_reg   = c_q.rg;
                mio_wdata = c_q.wdata;
            end
            OP_WDATA: begin
                mio_write = 1'b1;
                mio_reg   = OFS_DATA;
                mio_wdata = c_q.wdata;
            end
            OP_WCMD: begin
                mio_write = 1'b1;
                mio_wdata = cmd;
            end
            OP_RDATA: mio_reg = OFS_DATA;
            default: ;
        endcase
    end

    // sequencer next state
    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        c_d.tout  = 1'b0;
        c_d.err   = 1'b0;
        tmr_start = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.st     = ST_SEND;
                    c_d.step   = '0;
                    c_d.polls  = '0;
                    c_d.bus    = cfg_bus_addr;
                    c_d.tunnel = (cfg_bus_addr != '0);
                    c_d.wr     = req_write;
                    c_d.dev    = req_dev;
                    c_d.rg     = req_reg;
                    c_d.wdata  = req_wdata;
                end
            end
            ST_SEND: c_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mio_rsp_valid) begin
                    if (mio_rsp_err) begin
                        c_d.err = 1'b1;
                        c_d.st  = ST_IDLE;
                    end else if (op == OP_POLL && mio_rsp_rdata[BUSY_BIT]) begin
                        if (c_q.polls == POLL_LAST) begin
                            c_d.tout = 1'b1;
                            c_d.st   = ST_IDLE;
                        end else begin
                            c_d.polls = c_q.polls + 1'b1;
                            c_d.st    = ST_GAP;
                            tmr_start = 1'b1;
                        end
                    end else begin
                        c_d.polls = '0;
                        if (op == OP_RDATA || (op == OP_DIRECT && !c_q.wr))
                            c_d.rdata = mio_rsp_rdata;
                        if (last) begin
                            c_d.done = 1'b1;
                            c_d.st   = ST_IDLE;
                        end else begin
                            c_d.step = c_q.step + 2'd1;
                            c_d.st   = ST_SEND;
                        end
                    end
                end
            end
            ST_GAP: if (tmr_expired) c_d.st = ST_SEND;
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign req_ready   = (c_q.st == ST_IDLE);
    assign mio_req     = (c_q.st == ST_SEND);
    assign rsp_done    = c_q.done;
    assign rsp_timeout = c_q.tout;
    assign rsp_error   = c_q.err;
    assign rsp_rdata   = c_q.rdata;
endmodule

// File: rtl/smi_im_checker.sv
module smi_im_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic mio_req,
    input logic mio_rsp_valid,
    input logic rsp_done,
    input logic rsp_timeout,
    input logic rsp_error
);
    logic pending_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             pending_q <= 1'b0;
        else if (mio_req)       pending_q <= 1'b1;
        else if (mio_rsp_valid) pending_q <= 1'b0;
    end

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_done, rsp_timeout, rsp_error}));

    // R10
    outcome_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done || rsp_timeout || rsp_error) |-> req_ready);

    // R9
    no_frame_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mio_req);

    // R11
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mio_req |=> !mio_req);

    // R11
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q |-> !mio_req);
endmodule

bind smi_indirect_master smi_im_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mio_req       (mio_req),
    .mio_rsp_valid (mio_rsp_valid),
    .rsp_done      (rsp_done),
    .rsp_timeout   (rsp_timeout),
    .rsp_error     (rsp_error)
);

// File: tb/smi_indirect_master_tb_top.sv
module smi_indirect_master_tb_top;
    localparam int GAP   = 3;
    localparam int LIMIT = 100;
    localparam int LOGN  = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_bus_addr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [4:0]  req_dev = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done, rsp_timeout, rsp_error;
    logic [15:0] rsp_rdata;
    logic        mio_req, mio_write;
    logic [4:0]  mio_phy, mio_reg;
    logic [15:0] mio_wdata;
    logic        mio_rsp_valid = 1'b0;
    logic        mio_rsp_err = 1'b0;
    logic [15:0] mio_rsp_rdata = '0;

    always #2 clk = ~clk;   // 250 MHz

    smi_indirect_master #(.POLL_LIMIT(LIMIT), .POLL_GAP(GAP)) dut_i (.*);

    // target model
    logic [15:0] mem [0:31][0:31];
    logic [15:0] cmd_q = '0, dat_q = '0;
    int busy_left = 0, busy_after = 0, err_at = 0, nlog = 0, cyc = 0;
    logic        lg_wr   [0:LOGN-1];
    logic [4:0]  lg_phy  [0:LOGN-1];
    logic [4:0]  lg_reg  [0:LOGN-1];
    logic [15:0] lg_dat  [0:LOGN-1];
    int          lg_t    [0:LOGN-1];

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin : model
        logic [15:0] rd;
        rd = 16'hFFFF;
        mio_rsp_valid <= 1'b0;
        mio_rsp_err   <= 1'b0;
        if (rst_n && mio_req) begin
            if (nlog < LOGN) begin
                lg_wr[nlog] = mio_write; lg_phy[nlog] = mio_phy;
                lg_reg[nlog] = mio_reg;  lg_dat[nlog] = mio_wdata;
                lg_t[nlog] = cyc;
            end
            nlog = nlog + 1;
            if (nlog == err_at) begin
                mio_rsp_err <= 1'b1;
            end else if (cfg_bus_addr == 5'd0) begin
                if (mio_write) mem[mio_phy][mio_reg] = mio_wdata;
                else           rd = mem[mio_phy][mio_reg];
            end else if (mio_phy == cfg_bus_addr) begin
                if (mio_reg == 5'd0) begin
                    if (mio_write) begin
                        cmd_q = mio_wdata;
                        if (mio_wdata[15]) begin
                            if (mio_wdata[11:10] == 2'd2) dat_q = mem[mio_wdata[9:5]][mio_wdata[4:0]];
                            if (mio_wdata[11:10] == 2'd1) mem[mio_wdata[9:5]][mio_wdata[4:0]] = dat_q;
                            busy_left = busy_after;
                        end
                    end else begin
                        rd = {(busy_left > 0), cmd_q[14:0]};
                        if (busy_left > 0) busy_left = busy_left - 1;
                    end
                end else if (mio_reg == 5'd1) begin
                    if (mio_write) dat_q = mio_wdata;
                    else           rd = dat_q;
                end
            end
            mio_rsp_valid <= 1'b1;
            mio_rsp_rdata <= rd;
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // kind: 1 done, 2 timeout, 3 error, 0 none
    task automatic run_req(input logic [4:0] bus, input logic wr, input logic [4:0] dev,
                           input logic [4:0] rg, input logic [15:0] data,
                           output int kind, output logic [15:0] rd);
        @(negedge clk);
        cfg_bus_addr = bus; req_write = wr; req_dev = dev; req_reg = rg;
        req_wdata = data; req_valid = 1'b1; nlog = 0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
        kind = 0;
        for (int i = 0; i < 5000 && kind == 0; i++) begin
            if (rsp_done) kind = 1;
            else if (rsp_timeout) kind = 2;
            else if (rsp_error) kind = 3;
            if (kind != 0)
                chk(req_ready == 1'b1, "R2 ready back with outcome", req_ready, 1);
            else
                @(negedge clk);
        end
        rd = rsp_rdata;
        @(negedge clk);
        chk(!(rsp_done || rsp_timeout || rsp_error), "R10 outcome is one pulse",
            {rsp_done, rsp_timeout, rsp_error}, 0);
    endtask

    function automatic logic [15:0] cmdw(input logic wr, input logic [4:0] d, input logic [4:0] r);
        return {1'b1, 2'b00, 1'b1, (wr ? 2'd1 : 2'd2), d, r};
    endfunction

    // bus, dev, reg, data
    localparam logic [30:0] VEC [6] = '{
        {5'd0,  5'd2,  5'd4,  16'h1234},
        {5'd9,  5'd3,  5'd17, 16'hBEEF},
        {5'd0,  5'd31, 5'd31, 16'hFFFF},
        {5'd31, 5'd0,  5'd0,  16'h0001},
        {5'd1,  5'd27, 5'd1,  16'h8000},
        {5'd0,  5'd1,  5'd0,  16'h0000}
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        summary();
        $finish;
    end

    initial begin : main
        int kind;
        logic [15:0] rd;
        int snap;
        for (int d = 0; d < 32; d++)
            for (int r = 0; r < 32; r++) mem[d][r] = 16'(d * 32 + r);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(mio_req == 1'b0, "R1 no frame after reset", mio_req, 0);
        chk({rsp_done, rsp_timeout, rsp_error} == 3'b0, "R1 status idle",
            {rsp_done, rsp_timeout, rsp_error}, 0);

        // vector walk: write then read back; R3 direct, R4/R5 tunnelled
        for (int v = 0; v < 6; v++) begin
            logic [4:0] b, d, r; logic [15:0] x; int nf;
            {b, d, r, x} = VEC[v];
            nf = (b == 5'd0) ? 1 : 4;
            run_req(b, 1'b1, d, r, x, kind, rd);
            chk(kind == 1, "R5 vector write done", kind, 1);
            chk(nlog == nf, "R3 vector write frame count", nlog, nf);
            run_req(b, 1'b0, d, r, 16'h0, kind, rd);
            chk(kind == 1, "R4 vector read done", kind, 1);
            chk(rd == x, "R4 vector readback", rd, x);
            chk(nlog == nf, "R3 vector read frame count", nlog, nf);
        end
        // R3 fields of a direct frame
        run_req(5'd0, 1'b1, 5'd12, 5'd6, 16'h7E57, kind, rd);
        chk(lg_wr[0] && lg_phy[0] == 5'd12 && lg_reg[0] == 5'd6 && lg_dat[0] == 16'h7E57,
            "R3 direct frame fields", {lg_wr[0], lg_phy[0], lg_reg[0], lg_dat[0]}, {1'b1, 5'd12, 5'd6, 16'h7E57});
        // R3 direct mode ignores a busy target
        busy_left = 5;
        run_req(5'd0, 1'b0, 5'd12, 5'd6, 16'h0, kind, rd);
        chk(kind == 1 && nlog == 1, "R3 direct no polling", nlog, 1);
        busy_left = 0;

        // tunnelled read with busy polls: R4 R6 R7
        mem[5][7] = 16'hA5C3; busy_left = 2; busy_after = 1;
        run_req(5'd9, 1'b0, 5'd5, 5'd7, 16'h0, kind, rd);
        busy_after = 0;
        chk(kind == 1, "R4 read done", kind, 1);
        chk(rd == 16'hA5C3, "R4 read data", rd, 16'hA5C3);
        chk(nlog == 7, "R4 read frame count", nlog, 7);
        chk(!lg_wr[0] && lg_phy[0] == 5'd9 && lg_reg[0] == 5'd0, "R4 first poll", lg_reg[0], 0);
        chk(lg_wr[3] && lg_reg[3] == 5'd0, "R4 command write step", lg_reg[3], 0);
        chk(lg_dat[3] == cmdw(1'b0, 5'd5, 5'd7), "R6 read command word", lg_dat[3], cmdw(1'b0, 5'd5, 5'd7));
        chk(!lg_wr[6] && lg_reg[6] == 5'd1, "R4 data read last", lg_reg[6], 1);
        chk(lg_t[1] - lg_t[0] == GAP + 2, "R7 busy retry spacing", lg_t[1] - lg_t[0], GAP + 2);
        chk(lg_t[3] - lg_t[2] == 2, "R7 clear poll advances", lg_t[3] - lg_t[2], 2);

        // tunnelled write order: R5 R6 R10
        run_req(5'd9, 1'b1, 5'd6, 5'd2, 16'h0F0F, kind, rd);
        chk(kind == 1 && nlog == 4, "R5 write frame count", nlog, 4);
        chk(!lg_wr[0] && lg_reg[0] == 5'd0, "R5 leading poll", lg_reg[0], 0);
        chk(lg_wr[1] && lg_reg[1] == 5'd1 && lg_dat[1] == 16'h0F0F, "R5 data write", lg_dat[1], 16'h0F0F);
        chk(lg_wr[2] && lg_reg[2] == 5'd0 && lg_dat[2] == cmdw(1'b1, 5'd6, 5'd2),
            "R6 write command word", lg_dat[2], cmdw(1'b1, 5'd6, 5'd2));
        chk(!lg_wr[3] && lg_reg[3] == 5'd0, "R5 trailing poll", lg_reg[3], 0);
        chk(rd == 16'hA5C3, "R10 rdata held across write", rd, 16'hA5C3);
        chk(mem[6][2] == 16'h0F0F, "R5 target updated", mem[6][2], 16'h0F0F);

        // R8 stuck busy -> timeout after exactly LIMIT polls
        busy_left = 1000;
        run_req(5'd9, 1'b0, 5'd1, 5'd1, 16'h0, kind, rd);
        chk(kind == 2, "R8 timeout reported", kind, 2);
        snap = nlog;
        repeat (20) @(negedge clk);
        chk(nlog == LIMIT && snap == LIMIT, "R8 poll count at timeout", nlog, LIMIT);
        // R8 busy clears on the last allowed try
        busy_left = LIMIT - 1;
        run_req(5'd9, 1'b0, 5'd1, 5'd1, 16'h0, kind, rd);
        chk(kind == 1 && nlog == LIMIT + 3, "R8 clear on last try", nlog, LIMIT + 3);
        // R8 count restarts per poll phase
        busy_left = 60; busy_after = 60;
        run_req(5'd9, 1'b0, 5'd1, 5'd1, 16'h0, kind, rd);
        busy_after = 0;
        chk(kind == 1 && nlog == 124, "R8 per-phase poll count", nlog, 124);

        // R9 error aborts
        busy_left = 0; err_at = 2; mem[4][4] = 16'h5555;
        run_req(5'd9, 1'b1, 5'd4, 5'd4, 16'hAAAA, kind, rd);
        repeat (10) @(negedge clk);
        chk(kind == 3, "R9 error reported", kind, 3);
        chk(nlog == 2, "R9 no frame after error", nlog, 2);
        chk(mem[4][4] == 16'h5555, "R9 target untouched", mem[4][4], 16'h5555);
        err_at = 1;
        run_req(5'd0, 1'b0, 5'd4, 5'd4, 16'h0, kind, rd);
        chk(kind == 3 && nlog == 1, "R9 direct error", kind, 3);
        err_at = 0;

        summary();
        $finish;
    end
endmodule